// File: doc/BRIEF.md
# Package Low-Power State Resolver

This block decides the package-level idle state of a multi-core processor. Each core reports a 2-bit idle code. The block reduces these codes to the shallowest state that all cores share. When that state is C3 or C6, the block asks the platform for permission and holds the request open until the platform answers. The platform's answer caps the depth, so a request for C6 can be answered with C3 only. The resolved package state is active, C3 or C6.

In package C6 the block sends a one-cycle save strobe to every core. It collects one save acknowledge per core, in any order and across any number of cycles. Only when every core has acknowledged does it enable core-voltage reduction. The shared last-level cache is flagged to stay snoopable in both package low-power states.

A generic wake input, or any core rising above the entered depth, pulls the package back to active. This also cancels a pending permission request. When the voltage is already reduced, the exit takes one extra cycle, so that the voltage enable falls before the package reports active.

Top module: `lp_pkg_resolver`

## Requirements
- R1: After reset the package state is active (code 0), the permission request is low, the save strobe is all zeros, and both the voltage-reduce enable and the snoop flag are low.
- R2: Per-core codes are 0 = active, 1 = C1, 2 = C3, 3 = C6, with core i at bits [2i+1:2i]. When the package is active, wake is low and the minimum code over all cores is 2 or 3, the permission request rises on the next edge. The requested level equals that minimum. The request then holds until a grant is seen, a wake arrives, or a core rises above the requested level.
- R3: While the permission request is high the package state stays active; no low-power state is entered while permission is pending.
- R4: When a grant arrives with a pending request, the effective depth is the smaller of the requested level and the granted level. An effective depth of 2 puts the package in C3 (code 2) on the next edge, even if C6 was requested.
- R5: An effective depth of 3 puts the package in C6 (code 3) on the next edge. In that same cycle the save strobe is high on every core's bit, and it is high for that single cycle only.
- R6: The voltage-reduce enable rises on the edge after the last outstanding core acknowledge is seen. Acknowledges may arrive in different cycles. The enable is high only while the package is in C6.
- R7: The snoop flag is high in every cycle in which the package state is C3 or C6, and low while active.
- R8: A wake, or a minimum core code below the requested or entered depth, returns the package to active on the next edge and drops the permission request. This applies while a request is pending, in C3, or in C6 before the voltage is reduced. Wake takes precedence over a grant or a final acknowledge arriving in the same cycle.
- R9: When an exit condition is seen while the voltage is reduced, the voltage-reduce enable falls on the next edge while the package still reports C6. The package reports active on the edge after that.
- R10: A grant whose level is below 2 drops the request and leaves the package active.
- R11: A grant input seen while no request is pending has no effect on the package state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| core_cstate_i | input | 2*NUM_CORES | Per-core idle codes, core i at [2i+1:2i] |
| wake_i | input | 1 | Generic wake event |
| grant_valid_i | input | 1 | Platform answer valid; completes the request handshake |
| grant_level_i | input | 2 | Deepest level the platform allows |
| save_ack_i | input | NUM_CORES | Per-core state-save complete acknowledge |
| pkg_state_o | output | 2 | Package state: 0 active, 2 C3, 3 C6 |
| llc_snoop_o | output | 1 | Shared cache must stay powered and snoopable |
| save_req_o | output | NUM_CORES | One-cycle save strobe to each core |
| vreduce_o | output | 1 | Core voltage reduction enable |
| perm_req_o | output | 1 | Permission request to platform; held until answered |
| perm_level_o | output | 2 | Level being requested, valid with perm_req_o |

## Verification
Permission is a request/answer handshake. The request acts as valid and the grant as the answer. The platform exerts back-pressure by withholding the grant, and the request stays high with a stable level until the grant arrives.

The collisions that matter are an exit and an advance in the same cycle. One is a wake arriving in the same cycle as a grant. The other is a core leaving C6 in the same cycle as the final save acknowledge. The bench drives both inputs together in one cycle. It expects the exit to win, with the package reading active on the next edge, the request low, and no voltage reduction. A scoreboard queue holds the expected outputs for each driven cycle.

// File: rtl/lp_pkg_types.sv
package lp_pkg_types;

  // per-core idle codes
  localparam logic [1:0] CS_ACT = 2'd0;
  localparam logic [1:0] CS_C1  = 2'd1;
  localparam logic [1:0] CS_C3  = 2'd2;
  localparam logic [1:0] CS_C6  = 2'd3;

  // package state codes on the output
  localparam logic [1:0] PK_ACT = 2'd0;
  localparam logic [1:0] PK_C3  = 2'd2;
  localparam logic [1:0] PK_C6  = 2'd3;

  typedef enum logic [2:0] {
    ST_ACT  = 3'd0,
    ST_REQ  = 3'd1,
    ST_C3   = 3'd2,
    ST_SAVE = 3'd3,
    ST_C6   = 3'd4,
    ST_EXIT = 3'd5
  } pkg_fsm_e;

  function automatic logic [1:0] lvl_min(input logic [1:0] a, input logic [1:0] b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/lp_core_min.sv
module lp_core_min #(
  parameter int NUM_CORES = 4,
  localparam int CW = 2*NUM_CORES
) (
  input  logic [CW-1:0] core_cstate_i,
  output logic [1:0]    min_o
);
  import lp_pkg_types::*;

  logic [1:0] chain [NUM_CORES];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CORES; gi++) begin : g_min
      if (gi == 0) begin : g_first
        assign chain[gi] = core_cstate_i[1:0];
      end else begin : g_rest
        assign chain[gi] = lvl_min(core_cstate_i[2*gi +: 2], chain[gi-1]);
      end
    end
  endgenerate

  assign min_o = chain[NUM_CORES-1];

endmodule

// File: rtl/lp_save_tracker.sv
module lp_save_tracker #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 collect_i,
  input  logic [NUM_CORES-1:0] ack_i,
  output logic                 all_done_o
);
  logic [NUM_CORES-1:0] seen_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CORES; gi++) begin : g_seen
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            seen_q[gi] <= 1'b0;
        else if (!collect_i)    seen_q[gi] <= 1'b0;
        else if (ack_i[gi])     seen_q[gi] <= 1'b1;
      end
    end
  endgenerate

  assign all_done_o = collect_i && (&(seen_q | ack_i));

endmodule

// File: rtl/lp_pkg_fsm.sv
module lp_pkg_fsm (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             min_lvl_i,
  input  logic                   wake_i,
  input  logic                   grant_valid_i,
  input  logic [1:0]             grant_level_i,
  input  logic                   save_done_i,
  output lp_pkg_types::pkg_fsm_e state_o,
  output logic [1:0]             req_lvl_o,
  output logic                   save_pulse_o
);
  import lp_pkg_types::*;

  pkg_fsm_e   state_q, state_d;
  logic [1:0] req_q, req_d;
  logic       pulse_q, pulse_d;
  logic [1:0] eff_lvl;

  assign eff_lvl = lvl_min(grant_level_i, req_q);

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    pulse_d = 1'b0;
    unique case (state_q)
      ST_ACT: begin
        if (!wake_i && (min_lvl_i >= CS_C3)) begin
          state_d = ST_REQ;
          req_d   = min_lvl_i;
        end
      end
      ST_REQ: begin
        if (wake_i || (min_lvl_i < req_q)) begin
          state_d = ST_ACT;
        end else if (grant_valid_i) begin
          if (eff_lvl == CS_C6) begin
            state_d = ST_SAVE;
            pulse_d = 1'b1;
          end else if (eff_lvl == CS_C3) begin
            state_d = ST_C3;
          end else begin
            state_d = ST_ACT;
          end
        end
      end
      ST_C3: begin
        if (wake_i || (min_lvl_i < CS_C3)) state_d = ST_ACT;
      end
      ST_SAVE: begin
        if (wake_i || (min_lvl_i < CS_C6)) state_d = ST_ACT;
        else if (save_done_i)              state_d = ST_C6;
      end
      ST_C6: begin
        if (wake_i || (min_lvl_i < CS_C6)) state_d = ST_EXIT;
      end
      ST_EXIT: state_d = ST_ACT;
      default: state_d = ST_ACT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACT;
      req_q   <= CS_ACT;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      pulse_q <= pulse_d;
    end
  end

  assign state_o      = state_q;
  assign req_lvl_o    = req_q;
  assign save_pulse_o = pulse_q;

endmodule

// File: rtl/lp_pkg_resolver.sv
module lp_pkg_resolver #(
  parameter int NUM_CORES = 4,
  localparam int CW = 2*NUM_CORES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CW-1:0]        core_cstate_i,
  input  logic                 wake_i,
  input  logic                 grant_valid_i,
  input  logic [1:0]           grant_level_i,
  input  logic [NUM_CORES-1:0] save_ack_i,
  output logic [1:0]           pkg_state_o,
  output logic                 llc_snoop_o,
  output logic [NUM_CORES-1:0] save_req_o,
  output logic                 vreduce_o,
  output logic                 perm_req_o,
  output logic [1:0]           perm_level_o
);
  import lp_pkg_types::*;

  logic [1:0] min_lvl;
  logic       save_done;
  logic       save_pulse;
  logic [1:0] req_lvl;
  pkg_fsm_e   state;

  lp_core_min #(.NUM_CORES(NUM_CORES)) u_min (
    .core_cstate_i (core_cstate_i),
    .min_o         (min_lvl)
  );

  lp_save_tracker #(.NUM_CORES(NUM_CORES)) u_save (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .collect_i  (state == ST_SAVE),
    .ack_i      (save_ack_i),
    .all_done_o (save_done)
  );

  lp_pkg_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .min_lvl_i     (min_lvl),
    .wake_i        (wake_i),
    .grant_valid_i (grant_valid_i),
    .grant_level_i (grant_level_i),
    .save_done_i   (save_done),
    .state_o       (state),
    .req_lvl_o     (req_lvl),
    .save_pulse_o  (save_pulse)
  );

  always_comb begin
    unique case (state)
      ST_C3:                    pkg_state_o = PK_C3;
      ST_SAVE, ST_C6, ST_EXIT:  pkg_state_o = PK_C6;
      default:                  pkg_state_o = PK_ACT;
    endcase
  end

  assign llc_snoop_o  = (pkg_state_o != PK_ACT);
  assign save_req_o   = {NUM_CORES{save_pulse}};
  assign vreduce_o    = (state == ST_C6);
  assign perm_req_o   = (state == ST_REQ);
  assign perm_level_o = req_lvl;

endmodule

// File: rtl/lp_pkg_resolver_chk.sv
module lp_pkg_resolver_chk #(
  parameter int NUM_CORES = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wake_i,
  input logic                 grant_valid_i,
  input logic [1:0]           grant_level_i,
  input logic [1:0]           pkg_state_o,
  input logic                 llc_snoop_o,
  input logic [NUM_CORES-1:0] save_req_o,
  input logic                 vreduce_o,
  input logic                 perm_req_o
);

  assert_no_entry_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perm_req_o |-> (pkg_state_o == 2'd0));

  assert_demote_to_c3_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perm_req_o && grant_valid_i && grant_level_i == 2'd2) |=> (pkg_state_o != 2'd3));

  assert_strobe_all_cores_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_o != '0) |-> ((save_req_o == '1) && (pkg_state_o == 2'd3)));

  assert_strobe_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_req_o != '0) |=> (save_req_o == '0));

  assert_vred_in_c6_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vreduce_o |-> (pkg_state_o == 2'd3));

  assert_vred_after_save_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vreduce_o) |-> ($past(pkg_state_o) == 2'd3 && $past(save_req_o) == '0));

  assert_snoop_lowpower_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkg_state_o != 2'd0) |-> llc_snoop_o);

  assert_wake_cancels_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && perm_req_o) |=> (!perm_req_o && pkg_state_o == 2'd0));

  assert_vred_drop_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vreduce_o) |-> (pkg_state_o == 2'd3));

  assert_idle_grant_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!perm_req_o && grant_valid_i && pkg_state_o == 2'd0) |=> (pkg_state_o == 2'd0));

  assert_legal_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkg_state_o != 2'd1);

endmodule

bind lp_pkg_resolver lp_pkg_resolver_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wake_i        (wake_i),
  .grant_valid_i (grant_valid_i),
  .grant_level_i (grant_level_i),
  .pkg_state_o   (pkg_state_o),
  .llc_snoop_o   (llc_snoop_o),
  .save_req_o    (save_req_o),
  .vreduce_o     (vreduce_o),
  .perm_req_o    (perm_req_o)
);

// File: tb/lp_pkg_resolver_tb.sv
module lp_pkg_resolver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2*NC-1:0] cstate = '0;
  logic          wake = 1'b0;
  logic          gvalid = 1'b0;
  logic [1:0]    glevel = '0;
  logic [NC-1:0] sack = '0;
  logic [1:0]    pkg;
  logic          snoop;
  logic [NC-1:0] sreq;
  logic          vred;
  logic          preq;
  logic [1:0]    plvl;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [1:0] pkg;
    logic       preq;
    logic [1:0] plvl;
    logic       save;
    logic       vred;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_pkg_resolver #(.NUM_CORES(NC)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .core_cstate_i (cstate), .wake_i (wake),
    .grant_valid_i (gvalid), .grant_level_i (glevel), .save_ack_i (sack),
    .pkg_state_o (pkg), .llc_snoop_o (snoop), .save_req_o (sreq),
    .vreduce_o (vred), .perm_req_o (preq), .perm_level_o (plvl)
  );

  // driver: one cycle of stimulus plus the outputs expected after the next edge
  task automatic step(input logic [7:0] cs, input logic wk, input logic gv,
                      input logic [1:0] gl, input logic [3:0] ak,
                      input logic [1:0] e_pkg, input logic e_preq, input logic [1:0] e_lvl,
                      input logic e_save, input logic e_vred, input string tag);
    exp_t e;
    @(negedge clk);
    cstate = cs; wake = wk; gvalid = gv; glevel = gl; sack = ak;
    e.pkg = e_pkg; e.preq = e_preq; e.plvl = e_lvl; e.save = e_save; e.vred = e_vred; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        logic e_snoop;
        logic [NC-1:0] e_sreq;
        logic bad;
        e = sb_q.pop_front();
        e_snoop = (e.pkg != 2'd0);
        e_sreq  = e.save ? '1 : '0;
        bad = (pkg !== e.pkg) || (preq !== e.preq) || (vred !== e.vred) ||
              (sreq !== e_sreq) || (snoop !== e_snoop) ||
              (e.preq && (plvl !== e.plvl));
        checks++;
        if (bad) begin
          fails++;
          $display("FAIL %s: got pkg=%0d req=%0b lvl=%0d save=%b vred=%0b snoop=%0b, exp pkg=%0d req=%0b lvl=%0d save=%b vred=%0b snoop=%0b",
                   e.tag, pkg, preq, plvl, sreq, vred, snoop,
                   e.pkg, e.preq, e.plvl, e_sreq, e.vred, e_snoop);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*50000);
    fails++;
    checks++;
    $display("FAIL watchdog: got hung run, exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (pkg !== 2'd0 || preq !== 1'b0 || sreq !== '0 || vred !== 1'b0 || snoop !== 1'b0) begin
      fails++;
      $display("FAIL R1: got pkg=%0d req=%0b save=%b vred=%0b snoop=%0b, exp all zero",
               pkg, preq, sreq, vred, snoop);
    end
    rst_n = 1'b1;

    // R11 grant with nothing pending; R2 shallow core blocks request
    step(8'h00, 0, 1, 2'd3, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R11");
    step(8'hA9, 0, 0, 2'd0, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R2");

    // C3 entry, hold, exit by core (R2 R3 R4 R7 R8)
    step(8'hFB, 0, 0, 2'd0, 4'h0, 2'd0, 1, 2'd2, 0, 0, "R2");
    step(8'hFB, 0, 0, 2'd0, 4'h0, 2'd0, 1, 2'd2, 0, 0, "R3");
    step(8'hFB, 0, 1, 2'd3, 4'h0, 2'd2, 0, 2'd2, 0, 0, "R4");
    step(8'hFB, 0, 0, 2'd0, 4'h0, 2'd2, 0, 2'd2, 0, 0, "R7");
    step(8'hF9, 0, 0, 2'd0, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R8");
    step(8'h00, 0, 0, 2'd0, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R8");

    // C6 requested, demoted to C3, exit by wake (R4 R8)
    step(8'hFF, 0, 0, 2'd0, 4'h0, 2'd0, 1, 2'd3, 0, 0, "R2");
    step(8'hFF, 0, 1, 2'd2, 4'h0, 2'd2, 0, 2'd3, 0, 0, "R4");
    step(8'hFF, 1, 0, 2'd0, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R8");
    step(8'h00, 0, 0, 2'd0, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R8");

    // C6 with staggered acknowledges and exit (R5 R6 R9)
    step(8'hFF, 0, 0, 2'd0, 4'h0, 2'd0, 1, 2'd3, 0, 0, "R2");
    step(8'hFF, 0, 1, 2'd3, 4'h0, 2'd3, 0, 2'd3, 1, 0, "R5");
    step(8'hFF, 0, 0, 2'd0, 4'h1, 2'd3, 0, 2'd3, 0, 0, "R5");
    step(8'hFF, 0, 0, 2'd0, 4'h6, 2'd3, 0, 2'd3, 0, 0, "R6");
    step(8'hFF, 0, 0, 2'd0, 4'h0, 2'd3, 0, 2'd3, 0, 0, "R6");
    step(8'hFF, 0, 0, 2'd0, 4'h8, 2'd3, 0, 2'd3, 0, 1, "R6");
    step(8'hFF, 0, 0, 2'd0, 4'h0, 2'd3, 0, 2'd3, 0, 1, "R6");
    step(8'hFF, 1, 0, 2'd0, 4'h0, 2'd3, 0, 2'd3, 0, 0, "R9");
    step(8'h00, 0, 0, 2'd0, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R9");
    step(8'h00, 0, 0, 2'd0, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R9");

    // denial (R10)
    step(8'hFF, 0, 0, 2'd0, 4'h0, 2'd0, 1, 2'd3, 0, 0, "R2");
    step(8'hFF, 0, 1, 2'd1, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R10");
    step(8'h00, 0, 0, 2'd0, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R10");

    // wake collides with grant (R8)
    step(8'hAA, 0, 0, 2'd0, 4'h0, 2'd0, 1, 2'd2, 0, 0, "R2");
    step(8'hAA, 1, 1, 2'd3, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R8");
    step(8'h00, 0, 0, 2'd0, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R8");

    // core leaves C6 with final acknowledge during save (R8)
    step(8'hFF, 0, 0, 2'd0, 4'h0, 2'd0, 1, 2'd3, 0, 0, "R2");
    step(8'hFF, 0, 1, 2'd3, 4'h0, 2'd3, 0, 2'd3, 1, 0, "R5");
    step(8'hFE, 0, 0, 2'd0, 4'hF, 2'd0, 0, 2'd0, 0, 0, "R8");
    step(8'h00, 0, 0, 2'd0, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R8");

    // core goes active while request pending (R8)
    step(8'hFF, 0, 0, 2'd0, 4'h0, 2'd0, 1, 2'd3, 0, 0, "R2");
    step(8'h3F, 0, 0, 2'd0, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R8");
    step(8'h00, 0, 0, 2'd0, 4'h0, 2'd0, 0, 2'd0, 0, 0, "R8");

    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule